// File: doc/BRIEF.md
# Flyback Capacitor Charge Sequencer

This block is the digital sequencer of a flyback converter that charges a flash storage capacitor. It drives the request for the primary power switch. It also watches a set of comparator flags: peak primary current, secondary current reaching zero, full output voltage, supply undervoltage and overtemperature. From these flags it decides when each switching phase ends. Timers count both phases, so a missing comparator event cannot hold the switch on or off for ever.

Once the enable input goes high, the block waits a fixed startup delay and then alternates on-phases and off-phases until the full comparator trips. At that point it stops switching and pulls its active-low full indication low. Undervoltage and overtemperature suspend switching, and switching resumes by itself once the flags clear. A run of off-phases that all end on their timer points to a shorted output. When that run reaches a set length, the block locks itself off, and only a fresh enable edge with a healthy supply unlocks it. A separate gated output passes the flash trigger to the flash switch driver.

Top module: `flyback_charge_ctrl`

## Requirements
- R1: During and directly after a synchronous active-low reset, `gate_on` is 0 and `full_n` is 1.
- R2: From idle, the rising clock edge that first samples `chg_en` high counts as edge 1. `gate_on` first goes high after edge START_CYC+1.
- R3: `pk_hit` sampled high during an on-phase ends that phase, so a held `pk_hit` gives 1-cycle on-phases. Without `pk_hit`, an on-phase lasts exactly ON_MAX_CYC cycles.
- R4: `sec_zero` sampled high during an off-phase ends that phase. Without `sec_zero`, an off-phase lasts exactly OFF_MAX_CYC cycles.
- R5: `v_full` sampled high while enabled stops switching and drives `full_n` to 0 from the next edge. That state holds even after `v_full` clears, until `chg_en` goes low.
- R6: `chg_en` sampled low forces `gate_on` to 0 and `full_n` to 1 from the next edge.
- R7: While `uv_flag` or `ot_flag` is high, `gate_on` stays 0. Switching resumes without any toggle of `chg_en` once both flags are low.
- R8: After FAULT_LIMIT consecutive off-phases that each end on the off-time limit, the block latches a fault and produces no further on-phases.
- R9: An off-phase ended by `sec_zero`, or `chg_en` low, resets the consecutive count to zero.
- R10: The fault clears only on a 0-to-1 transition of `chg_en` sampled while `uv_flag` is 0. A rising edge during undervoltage leaves the fault in place, even after the undervoltage clears.
- R11: `flash_drv` equals `flash_req` AND `flash_en` AND NOT `uv_flag`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chg_en | input | 1 | Charge enable |
| pk_hit | input | 1 | Primary peak-current comparator flag |
| sec_zero | input | 1 | Secondary current finished flag |
| v_full | input | 1 | Output voltage at full-charge level |
| uv_flag | input | 1 | Supply undervoltage flag |
| ot_flag | input | 1 | Overtemperature flag |
| flash_req | input | 1 | Flash trigger request |
| flash_en | input | 1 | Flash driver enable |
| gate_on | output | 1 | Power switch on request |
| full_n | output | 1 | Full-charge indication, active low |
| flash_drv | output | 1 | Gated flash driver output |

## Verification
The short-output lockout is the hardest state to reach. It needs an unbroken run of timer-ended off-phases, and a single early `sec_zero` must be shown to restart that run. The stimulus shrinks the fault limit and the timers through parameters. It holds `pk_hit` high, so each switching period lasts only a few cycles, and counts on-pulses at the port. One `sec_zero` pulse is placed inside the fourth off-phase, and the run then needs nine pulses instead of five before switching stops. The unlock path is then tried twice: first with undervoltage present during the enable edge, which must leave the fault locked, and then with a clean edge, which must restart switching.

// File: rtl/fcc_pkg.sv
// Package: shared state encoding for the flyback charge sequencer.
package fcc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ON,
        ST_OFF,
        ST_FULL,
        ST_PAUSE,
        ST_FAULT
    } fcc_state_e;
endpackage

// File: rtl/fcc_phase_timer.sv
// Module: fcc_phase_timer
// Counts clock cycles spent in the current controller state.
// Assumes the caller pulses clr on every state change. The count saturates
// at all-ones, so it never wraps back to a value that would look like a limit.
module fcc_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    // Cycle counter: cleared on reset or phase change, otherwise saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fcc_short_guard.sv
// Module: fcc_short_guard
// Counts consecutive off-phases that ended on the off-time limit and raises
// trip on the one that reaches LIMIT. Assumes LIMIT >= 2 and that the caller
// turns trip into a latched fault state.
module fcc_short_guard #(
    parameter int LIMIT = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic expire_tick,
    output logic trip
);
    localparam int CW = $clog2(LIMIT);

    logic [CW-1:0] run_cnt;

    assign trip = expire_tick && (run_cnt == CW'(LIMIT - 1));

    // Run counter: counts each timed-out off-phase; cleared by the caller or on trip.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_cnt <= '0;
        end else if (expire_tick) begin
            run_cnt <= trip ? '0 : run_cnt + 1'b1;
        end
    end

    // R9: a clear always leaves the count at zero on the next cycle.
    a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (run_cnt == '0));
endmodule

// File: rtl/fcc_flash_gate.sv
// Module: fcc_flash_gate
// Passes the flash trigger to the driver only when the driver is enabled and
// the supply is healthy. Purely combinational; assumes the inputs are already
// synchronous to the system clock.
module fcc_flash_gate (
    input  logic flash_req,
    input  logic flash_en,
    input  logic uv_flag,
    output logic flash_drv
);
    // Gate: all three conditions must hold.
    always_comb flash_drv = flash_req & flash_en & ~uv_flag;
endmodule

// File: rtl/flyback_charge_ctrl.sv
// Module: flyback_charge_ctrl (top)
// Sequences a flyback charger. After a startup delay it alternates timed
// on-phases and off-phases, stops at full voltage, pauses on undervoltage or
// overtemperature, and latches off after a long run of timed-out off-phases.
// Assumes every flag input is already synchronous to clk. Timer limits are in
// clock cycles.
module flyback_charge_ctrl
    import fcc_pkg::*;
#(
    parameter int ON_MAX_CYC  = 250,
    parameter int OFF_MAX_CYC = 50,
    parameter int START_CYC   = 600,
    parameter int FAULT_LIMIT = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_en,
    input  logic pk_hit,
    input  logic sec_zero,
    input  logic v_full,
    input  logic uv_flag,
    input  logic ot_flag,
    input  logic flash_req,
    input  logic flash_en,
    output logic gate_on,
    output logic full_n,
    output logic flash_drv
);
    localparam int TMAX12 = (ON_MAX_CYC > OFF_MAX_CYC) ? ON_MAX_CYC : OFF_MAX_CYC;
    localparam int TMAX   = (TMAX12 > START_CYC) ? TMAX12 : START_CYC;
    localparam int TW     = $clog2(TMAX + 1);
    localparam logic [TW-1:0] ON_LAST    = TW'(ON_MAX_CYC - 1);
    localparam logic [TW-1:0] OFF_LAST   = TW'(OFF_MAX_CYC - 1);
    localparam logic [TW-1:0] START_LAST = TW'(START_CYC - 1);

    fcc_state_e    state, state_nx;
    logic [TW-1:0] tmr;
    logic          chg_en_q;
    logic          en_rise;
    logic          off_expire;
    logic          sec_clear;
    logic          trip;
    logic          guard_clr;

    assign en_rise   = chg_en && !chg_en_q;
    assign guard_clr = !chg_en || sec_clear;

    fcc_phase_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_nx != state),
        .cnt   (tmr)
    );

    fcc_short_guard #(.LIMIT(FAULT_LIMIT)) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (guard_clr),
        .expire_tick (off_expire),
        .trip        (trip)
    );

    fcc_flash_gate u_flash (
        .flash_req (flash_req),
        .flash_en  (flash_en),
        .uv_flag   (uv_flag),
        .flash_drv (flash_drv)
    );

    // Next state: fault latch first, then enable, full hold, pauses, full trip, phase timing.
    always_comb begin
        state_nx   = state;
        off_expire = 1'b0;
        sec_clear  = 1'b0;
        if (state == ST_FAULT) begin
            if (en_rise && !uv_flag) state_nx = ST_START;
        end else if (!chg_en) begin
            state_nx = ST_IDLE;
        end else if (state == ST_FULL) begin
            state_nx = ST_FULL;
        end else if (uv_flag || ot_flag) begin
            state_nx = ST_PAUSE;
        end else if (v_full) begin
            state_nx = ST_FULL;
        end else begin
            case (state)
                ST_IDLE:  state_nx = ST_START;
                ST_START: if (tmr == START_LAST) state_nx = ST_ON;
                ST_ON:    if (pk_hit || tmr == ON_LAST) state_nx = ST_OFF;
                ST_OFF: begin
                    if (sec_zero) begin
                        sec_clear = 1'b1;
                        state_nx  = ST_ON;
                    end else if (tmr == OFF_LAST) begin
                        off_expire = 1'b1;
                        state_nx   = trip ? ST_FAULT : ST_ON;
                    end
                end
                ST_PAUSE: state_nx = ST_ON;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // State and enable-history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            chg_en_q <= 1'b0;
        end else begin
            state    <= state_nx;
            chg_en_q <= chg_en;
        end
    end

    // Outputs decoded from the registered state.
    always_comb begin
        gate_on = (state == ST_ON);
        full_n  = (state != ST_FULL);
    end

    // Checker counter: consecutive cycles gate_on has already been high.
    logic [TW:0] on_run;
    always_ff @(posedge clk) begin
        if (!rst_n || !gate_on) on_run <= '0;
        else                    on_run <= on_run + 1'b1;
    end

    a_r6_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_en |=> (!gate_on && full_n));
    a_r7_pause_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_en && (uv_flag || ot_flag)) |=> !gate_on);
    a_r5_full_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_n) |-> $past(v_full));
    a_r3_on_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        gate_on |-> (on_run < (TW+1)'(ON_MAX_CYC)));
    a_r11_uv_blocks_flash: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |-> !flash_drv);
    a_r10_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT && !chg_en) |=> (state == ST_FAULT));
    a_r8_trip_enters_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && chg_en && !uv_flag && !ot_flag && !v_full) |=> (state == ST_FAULT));
endmodule

// File: tb/test_flyback_charge_ctrl.sv
// Bench: table-driven check of the flash gate, then directed sequencer tests.
module test_flyback_charge_ctrl;
    localparam int ONC = 8;
    localparam int OFFC = 4;
    localparam int STC = 6;
    localparam int FLIM = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chg_en = 0, pk_hit = 0, sec_zero = 0, v_full = 0;
    logic uv_flag = 0, ot_flag = 0, flash_req = 0, flash_en = 0;
    logic gate_on, full_n, flash_drv;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic gate_prev = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flyback_charge_ctrl #(
        .ON_MAX_CYC(ONC), .OFF_MAX_CYC(OFFC), .START_CYC(STC), .FAULT_LIMIT(FLIM)
    ) i_flyback_charge_ctrl (
        .clk(clk), .rst_n(rst_n), .chg_en(chg_en), .pk_hit(pk_hit),
        .sec_zero(sec_zero), .v_full(v_full), .uv_flag(uv_flag),
        .ot_flag(ot_flag), .flash_req(flash_req), .flash_en(flash_en),
        .gate_on(gate_on), .full_n(full_n), .flash_drv(flash_drv)
    );

    // Pulse monitor: counts rising edges of gate_on seen at falling clock edges.
    always @(negedge clk) begin
        if (gate_on && !gate_prev) pulses <= pulses + 1;
        gate_prev <= gate_on;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Waits for a fresh rising gate, then measures the high run and the low run.
    task automatic runs(output int hi, output int lo);
        while (gate_on) @(negedge clk);
        while (!gate_on) @(negedge clk);
        hi = 0;
        while (gate_on) begin hi++; @(negedge clk); end
        lo = 0;
        while (!gate_on) begin lo++; @(negedge clk); end
    endtask

    // Flash gate vectors: {flash_req, flash_en, uv_flag, expected flash_drv}
    localparam logic [3:0] FLASH_TBL [8] = '{
        4'b0000, 4'b0010, 4'b0100, 4'b0110,
        4'b1000, 4'b1010, 4'b1101, 4'b1110
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int hi, lo, n, first, base;
        cyc(3);
        // R1: reset values
        chk(gate_on == 0, "R1 gate in reset", gate_on, 0);
        chk(full_n == 1, "R1 full_n in reset", full_n, 1);
        rst_n = 1'b1;
        cyc(1);
        chk(gate_on == 0 && full_n == 1, "R1 after reset", {gate_on, full_n}, 1);

        // R11: table walk of the flash gate
        foreach (FLASH_TBL[i]) begin
            {flash_req, flash_en, uv_flag} = FLASH_TBL[i][3:1];
            #1;
            chk(flash_drv == FLASH_TBL[i][0], "R11 flash gate", flash_drv, FLASH_TBL[i][0]);
        end
        {flash_req, flash_en, uv_flag} = 3'b000;
        cyc(2);

        // R2: startup delay
        chg_en = 1'b1;
        first = 0;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            if (gate_on && first == 0) first = k;
        end
        chk(first == STC + 1, "R2 startup delay", first, STC + 1);

        // R3/R4: timed phases with no comparator events
        runs(hi, lo);
        chk(hi == ONC, "R3 on max time", hi, ONC);
        chk(lo == OFFC, "R4 off max time", lo, OFFC);

        // R3/R4: comparator-ended phases
        pk_hit = 1'b1; sec_zero = 1'b1;
        runs(hi, lo);
        chk(hi == 1, "R3 peak ends on phase", hi, 1);
        chk(lo == 1, "R4 off detect ends off phase", lo, 1);

        // R7: overtemperature pause and auto resume
        ot_flag = 1'b1;
        cyc(1);
        n = 0;
        for (int k = 0; k < 10; k++) begin
            if (gate_on) n++;
            @(negedge clk);
        end
        chk(n == 0, "R7 ot pause", n, 0);
        ot_flag = 1'b0;
        base = pulses;
        cyc(12);
        chk(pulses - base > 0, "R7 ot resume", pulses - base, 1);

        // R7/R11: undervoltage pause with flash forced low
        flash_req = 1'b1; flash_en = 1'b1;
        uv_flag = 1'b1;
        cyc(1);
        n = 0;
        for (int k = 0; k < 10; k++) begin
            if (gate_on) n++;
            @(negedge clk);
        end
        chk(n == 0, "R7 uv pause", n, 0);
        chk(flash_drv == 0, "R11 uv blocks flash", flash_drv, 0);
        uv_flag = 1'b0;
        #1;
        chk(flash_drv == 1, "R11 flash passes", flash_drv, 1);
        base = pulses;
        cyc(12);
        chk(pulses - base > 0, "R7 uv resume", pulses - base, 1);
        flash_req = 1'b0; flash_en = 1'b0;

        // R5: full voltage stops switching and is held
        v_full = 1'b1;
        cyc(1);
        chk(gate_on == 0 && full_n == 0, "R5 full stop", {gate_on, full_n}, 0);
        v_full = 1'b0;
        base = pulses;
        cyc(10);
        chk(full_n == 0 && pulses == base, "R5 full held", {full_n, 4'(pulses - base)}, 0);

        // R6: enable low releases full flag
        chg_en = 1'b0;
        cyc(1);
        chk(full_n == 1 && gate_on == 0, "R6 disable", {gate_on, full_n}, 1);
        cyc(3);

        // R8: short-output lockout after FLIM timed-out off phases
        pk_hit = 1'b1; sec_zero = 1'b0;
        base = pulses;
        chg_en = 1'b1;
        cyc(150);
        chk(pulses - base == FLIM, "R8 pulses before lockout", pulses - base, FLIM);
        chk(gate_on == 0 && full_n == 1, "R8 locked off", {gate_on, full_n}, 1);

        // R10: enable edge during undervoltage keeps the fault
        chg_en = 1'b0; cyc(2);
        uv_flag = 1'b1; chg_en = 1'b1; cyc(3);
        uv_flag = 1'b0;
        base = pulses;
        cyc(40);
        chk(pulses == base, "R10 uv edge ignored", pulses - base, 0);

        // R10/R9: clean edge restarts; one off-detect resets the run
        chg_en = 1'b0; cyc(2);
        base = pulses;
        chg_en = 1'b1;
        while (pulses - base < 4) @(negedge clk);
        while (gate_on) @(negedge clk);
        sec_zero = 1'b1;
        cyc(1);
        sec_zero = 1'b0;
        cyc(150);
        chk(pulses - base == 4 + FLIM, "R9 run reset by off detect", pulses - base, 4 + FLIM);
        chk(pulses - base > 0, "R10 clean edge clears fault", pulses - base, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule